// File: doc/BRIEF.md
# Multi-Block Descriptor Handshake Controller

This block runs one channel of a multi-block DMA transfer whose per-block control words come from a shadow register set. Software fills the shadow set with a control payload and three flags: valid, last, and interrupt-on-completion. At each block boundary the controller checks the valid flag. If the flag is set, the controller copies the set into the active control register and clears the valid flag, which hands ownership back to software. If the flag is clear, the controller discards the set, can raise an error, and halts the channel. The channel stays halted until software writes any value to the resume address.

The end of each block's bus traffic arrives as a single-cycle `blk_done` pulse. When the active word is marked last, the transfer ends after that block. Otherwise the next descriptor is fetched. In prefetch mode the controller takes the next descriptor into a staging register while the current block is still running. An invalid descriptor seen during prefetch raises no error. The real check happens at the boundary retry.

Software reaches the block through a single-cycle write port with four addresses. Three interrupt sources are sticky and cleared by writing ones: block done, invalid descriptor, and write while valid. Each source is gated by a status-enable bit and by a signal-enable bit.

Top module: `blkseq_ctrl`

## Requirements
- R1: After reset the controller is idle. A `ch_enable` pulse in the idle state makes `busy` rise at the next edge, with the controller in its fetch step. A `ch_enable` pulse in any other state is ignored.
- R2: In the fetch step with the shadow valid flag at 1, the controller does two things at the next edge. It loads {last, ioc, payload} into the active register and clears the shadow valid flag. `blk_start` is high for that one cycle. The block then waits for `blk_done`.
- R3: In the fetch step with the shadow valid flag at 0, the controller discards the set and `halted` rises at the next edge. Status bit 1 (invalid descriptor) is set if `stat_en[1]` is 1 and stays clear if `stat_en[1]` is 0.
- R4: The controller stays halted until a write to address 2 (resume, any data). It then repeats the fetch step, which may halt again.
- R5: Shadow write port layout: a write to address 0 carries data bit CTRL_W+2 = valid, bit CTRL_W+1 = last, bit CTRL_W = ioc, and the lower CTRL_W bits = payload. The write takes effect only while the shadow valid flag is 0. While the flag is 1, the write is dropped and status bit 2 is set if `stat_en[2]` is 1.
- R6: `blk_done` counts only while the controller waits for it. If the active word is last, `xfer_done` pulses for one cycle and the controller returns to idle. If the active word is not last, a new descriptor is fetched.
- R7: Status bit 0 is set on a counted `blk_done` only when the active ioc bit is 1 and `stat_en[0]` is 1. `irq` is high whenever a status bit is set and its `sig_en` bit is also set.
- R8: A write to address 1 (data bits CTRL_W+1..0 = last, ioc, payload) loads the active register only while the controller is idle. Otherwise it is ignored.
- R9: When `prefetch_en` is 1 and the active word is not last, the controller tries to prefetch while a block runs. On the block start cycle, or any waiting cycle without `blk_done`, it moves a valid shadow set into the staging register and clears the shadow valid flag. If the shadow set is invalid, no error is raised. At `blk_done` a staged word becomes active directly. With nothing staged, the normal fetch step runs and can raise the error.
- R10: A write to address 3 clears the status bits whose data bits (2..0) are 1. A set event in the same cycle takes priority over the clear.
- R11: `ch_disable` returns the controller to idle at the next edge from any state. It drops any staged word and cancels that cycle's state actions, but leaves the shadow set unchanged.
- R12: Reset clears the state, the shadow set, the active register, the staging register and all status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_enable | input | 1 | Start pulse |
| ch_disable | input | 1 | Abort to idle |
| prefetch_en | input | 1 | Enable descriptor prefetch |
| blk_done | input | 1 | Current block's bus traffic finished |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_addr | input | 2 | 0 shadow, 1 active, 2 resume, 3 status clear |
| sw_wr_data | input | CTRL_W+3 | Write data |
| stat_en | input | 3 | Status enables {wov, invalid, block} |
| sig_en | input | 3 | Interrupt signal enables |
| busy | output | 1 | Controller not idle |
| halted | output | 1 | Halted on invalid descriptor |
| blk_start | output | 1 | First cycle of a block |
| xfer_done | output | 1 | Transfer finished pulse |
| shadow_valid | output | 1 | Shadow valid flag |
| active_ctrl | output | CTRL_W | Active control payload |
| active_ioc | output | 1 | Active interrupt-on-completion bit |
| active_last | output | 1 | Active last bit |
| int_status | output | 3 | Sticky status {wov, invalid, block} |
| irq | output | 1 | Interrupt output |

## Verification
The hardest case to reach from the ports is a successful prefetch. After the fetch step clears the shadow valid flag, software can only refill the set on a later cycle. A prefetch therefore happens only if software writes a new valid set while the block waits for `blk_done`. The bench does this and then writes a third set during the staged block, so that a staged-to-active handoff chains into a second prefetch on the block-start cycle. A separate run leaves the shadow set invalid through a prefetched block and checks that the error appears only after `blk_done`. A status-clear write is also issued in the same cycle as a counted `blk_done`, to check that the set takes priority.

// File: rtl/blkseq_pkg.sv
package blkseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_FETCH     = 3'd1,
    ST_ACTIVE    = 3'd2,
    ST_WAIT_DONE = 3'd3,
    ST_HALTED    = 3'd4,
    ST_DONE      = 3'd5
  } seq_state_t;

  localparam int unsigned IRQ_N   = 3;
  localparam int unsigned IRQ_BLK = 0;
  localparam int unsigned IRQ_INV = 1;
  localparam int unsigned IRQ_WOV = 2;

  localparam logic [1:0] A_SHADOW = 2'd0;
  localparam logic [1:0] A_ACTIVE = 2'd1;
  localparam logic [1:0] A_RESUME = 2'd2;
  localparam logic [1:0] A_ISTAT  = 2'd3;
endpackage

// File: rtl/blkseq_shadow.sv
module blkseq_shadow #(
  parameter int unsigned BODY_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic              wr_valid,
  input  logic [BODY_W-1:0] wr_body,
  input  logic              clr,
  output logic              valid,
  output logic [BODY_W-1:0] body,
  output logic              wov
);
  logic body_en;
  logic valid_en;
  logic valid_d;

  always_comb begin
    body_en  = wr_req & ~valid;
    valid_en = body_en | clr;
    valid_d  = body_en ? wr_valid : 1'b0;
    wov      = wr_req & valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      body  <= '0;
    end else begin
      if (valid_en) valid <= valid_d;
      if (body_en)  body  <= wr_body;
    end
  end
endmodule

// File: rtl/blkseq_fsm.sv
module blkseq_fsm
  import blkseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ch_enable,
  input  logic       ch_disable,
  input  logic       prefetch_en,
  input  logic       blk_done,
  input  logic       resume_req,
  input  logic       shd_valid,
  input  logic       act_last,
  input  logic       stg_valid,
  output seq_state_t state,
  output logic       ld_shadow,
  output logic       ld_stage,
  output logic       pf_take,
  output logic       inv_evt,
  output logic       blk_evt
);
  seq_state_t state_d;
  logic       pf_window;

  always_comb begin
    ld_shadow = (state == ST_FETCH) & shd_valid & ~ch_disable;
    inv_evt   = (state == ST_FETCH) & ~shd_valid & ~ch_disable;
    blk_evt   = (state == ST_WAIT_DONE) & blk_done & ~ch_disable;
    ld_stage  = blk_evt & ~act_last & stg_valid;
    pf_window = (state == ST_ACTIVE) | ((state == ST_WAIT_DONE) & ~blk_done);
    pf_take   = pf_window & prefetch_en & ~act_last & ~stg_valid & shd_valid & ~ch_disable;
  end

  always_comb begin
    state_d = state;
    unique case (state)
      ST_IDLE:      if (ch_enable) state_d = ST_FETCH;
      ST_FETCH:     state_d = shd_valid ? ST_ACTIVE : ST_HALTED;
      ST_ACTIVE:    state_d = ST_WAIT_DONE;
      ST_WAIT_DONE: begin
        if (blk_done) begin
          if (act_last)       state_d = ST_DONE;
          else if (stg_valid) state_d = ST_ACTIVE;
          else                state_d = ST_FETCH;
        end
      end
      ST_HALTED:    if (resume_req) state_d = ST_FETCH;
      ST_DONE:      state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
    if (ch_disable) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_d;
  end
endmodule

// File: rtl/blkseq_active.sv
module blkseq_active #(
  parameter int unsigned BODY_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_shadow,
  input  logic              ld_stage,
  input  logic              pf_take,
  input  logic              dis,
  input  logic              direct_wr,
  input  logic [BODY_W-1:0] shd_body,
  input  logic [BODY_W-1:0] wr_body,
  output logic [BODY_W-1:0] act_body,
  output logic              stg_valid
);
  logic [BODY_W-1:0] stg_body;
  logic [BODY_W-1:0] act_d;
  logic              act_en;
  logic              stgv_en;
  logic              stgv_d;

  always_comb begin
    act_en = ld_shadow | ld_stage | direct_wr;
    if (ld_shadow)     act_d = shd_body;
    else if (ld_stage) act_d = stg_body;
    else               act_d = wr_body;
    stgv_en = pf_take | ld_stage | dis;
    stgv_d  = pf_take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_body  <= '0;
      stg_body  <= '0;
      stg_valid <= 1'b0;
    end else begin
      if (act_en)  act_body  <= act_d;
      if (pf_take) stg_body  <= shd_body;
      if (stgv_en) stg_valid <= stgv_d;
    end
  end
endmodule

// File: rtl/blkseq_irq.sv
module blkseq_irq #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_in,
  input  logic [N-1:0] stat_en,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] sig_en,
  output logic [N-1:0] status,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic set_i;
    logic en_i;
    assign set_i = set_in[i] & stat_en[i];
    assign en_i  = set_i | clr_mask[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    status[i] <= 1'b0;
      else if (en_i) status[i] <= set_i;
    end
  end

  assign irq = |(status & sig_en);
endmodule

// File: rtl/blkseq_ctrl.sv
module blkseq_ctrl
  import blkseq_pkg::*;
#(
  parameter int unsigned CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ch_enable,
  input  logic              ch_disable,
  input  logic              prefetch_en,
  input  logic              blk_done,
  input  logic              sw_wr_en,
  input  logic [1:0]        sw_wr_addr,
  input  logic [CTRL_W+2:0] sw_wr_data,
  input  logic [2:0]        stat_en,
  input  logic [2:0]        sig_en,
  output logic              busy,
  output logic              halted,
  output logic              blk_start,
  output logic              xfer_done,
  output logic              shadow_valid,
  output logic [CTRL_W-1:0] active_ctrl,
  output logic              active_ioc,
  output logic              active_last,
  output logic [2:0]        int_status,
  output logic              irq
);
  localparam int unsigned BODY_W = CTRL_W + 2;
  localparam int unsigned IOC_B  = CTRL_W;
  localparam int unsigned LAST_B = CTRL_W + 1;
  localparam int unsigned VAL_B  = CTRL_W + 2;

  seq_state_t        state;
  logic              ld_shadow, ld_stage, pf_take, inv_evt, blk_evt;
  logic              shd_wr, resume_req, direct_wr, wov;
  logic              stg_valid;
  logic [BODY_W-1:0] shd_body;
  logic [BODY_W-1:0] act_body;
  logic [IRQ_N-1:0]  clr_mask;
  logic [IRQ_N-1:0]  set_vec;

  always_comb begin
    shd_wr     = sw_wr_en & (sw_wr_addr == A_SHADOW);
    resume_req = sw_wr_en & (sw_wr_addr == A_RESUME);
    direct_wr  = sw_wr_en & (sw_wr_addr == A_ACTIVE) & (state == ST_IDLE);
    clr_mask   = (sw_wr_en & (sw_wr_addr == A_ISTAT)) ? sw_wr_data[IRQ_N-1:0] : '0;
    set_vec    = '0;
    set_vec[IRQ_BLK] = blk_evt & act_body[IOC_B];
    set_vec[IRQ_INV] = inv_evt;
    set_vec[IRQ_WOV] = wov;
  end

  blkseq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .ch_enable  (ch_enable),
    .ch_disable (ch_disable),
    .prefetch_en(prefetch_en),
    .blk_done   (blk_done),
    .resume_req (resume_req),
    .shd_valid  (shadow_valid),
    .act_last   (act_body[LAST_B]),
    .stg_valid  (stg_valid),
    .state      (state),
    .ld_shadow  (ld_shadow),
    .ld_stage   (ld_stage),
    .pf_take    (pf_take),
    .inv_evt    (inv_evt),
    .blk_evt    (blk_evt)
  );

  blkseq_shadow #(.BODY_W(BODY_W)) u_shadow (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (shd_wr),
    .wr_valid(sw_wr_data[VAL_B]),
    .wr_body (sw_wr_data[BODY_W-1:0]),
    .clr     (ld_shadow | pf_take),
    .valid   (shadow_valid),
    .body    (shd_body),
    .wov     (wov)
  );

  blkseq_active #(.BODY_W(BODY_W)) u_active (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_shadow(ld_shadow),
    .ld_stage (ld_stage),
    .pf_take  (pf_take),
    .dis      (ch_disable),
    .direct_wr(direct_wr),
    .shd_body (shd_body),
    .wr_body  (sw_wr_data[BODY_W-1:0]),
    .act_body (act_body),
    .stg_valid(stg_valid)
  );

  blkseq_irq #(.N(IRQ_N)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_in  (set_vec),
    .stat_en (stat_en),
    .clr_mask(clr_mask),
    .sig_en  (sig_en),
    .status  (int_status),
    .irq     (irq)
  );

  assign busy        = (state != ST_IDLE);
  assign halted      = (state == ST_HALTED);
  assign blk_start   = (state == ST_ACTIVE);
  assign xfer_done   = (state == ST_DONE);
  assign active_ctrl = act_body[CTRL_W-1:0];
  assign active_ioc  = act_body[IOC_B];
  assign active_last = act_body[LAST_B];
endmodule

// File: rtl/blkseq_ctrl_chk.sv
module blkseq_ctrl_chk
  import blkseq_pkg::*;
#(
  parameter int unsigned CTRL_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input seq_state_t        state,
  input logic              ch_disable,
  input logic              blk_done,
  input logic              sw_wr_en,
  input logic [1:0]        sw_wr_addr,
  input logic [2:0]        stat_en,
  input logic              busy,
  input logic              halted,
  input logic              blk_start,
  input logic              xfer_done,
  input logic              shadow_valid,
  input logic [CTRL_W+1:0] shd_body,
  input logic [CTRL_W-1:0] active_ctrl,
  input logic              active_last,
  input logic [2:0]        int_status
);
  logic wr_shd, wr_act, wr_res;
  assign wr_shd = sw_wr_en && (sw_wr_addr == A_SHADOW);
  assign wr_act = sw_wr_en && (sw_wr_addr == A_ACTIVE);
  assign wr_res = sw_wr_en && (sw_wr_addr == A_RESUME);

  // R2
  fetch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH && shadow_valid && !ch_disable) |=> (!shadow_valid && blk_start));

  // R3
  inv_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH && !shadow_valid && !ch_disable) |=> halted);

  // R4
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !wr_res && !ch_disable) |=> halted);

  // R4
  resume_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && wr_res && !ch_disable) |=> (state == ST_FETCH));

  // R5
  wov_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_shd && shadow_valid) |=> $stable(shd_body));

  // R5
  wov_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_shd && shadow_valid && stat_en[IRQ_WOV]) |=> int_status[IRQ_WOV]);

  // R6
  last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_DONE && blk_done && active_last && !ch_disable) |=> xfer_done);

  // R8
  act_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_act && state != ST_FETCH && !blk_done) |=> $stable(active_ctrl));

  // R11
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_disable |=> !busy);
endmodule

bind blkseq_ctrl blkseq_ctrl_chk #(.CTRL_W(CTRL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .state       (state),
  .ch_disable  (ch_disable),
  .blk_done    (blk_done),
  .sw_wr_en    (sw_wr_en),
  .sw_wr_addr  (sw_wr_addr),
  .stat_en     (stat_en),
  .busy        (busy),
  .halted      (halted),
  .blk_start   (blk_start),
  .xfer_done   (xfer_done),
  .shadow_valid(shadow_valid),
  .shd_body    (shd_body),
  .active_ctrl (active_ctrl),
  .active_last (active_last),
  .int_status  (int_status)
);

// File: tb/blkseq_ctrl_test.sv
module blkseq_ctrl_test;
  localparam int CW = 16;
  localparam int M_IDLE = 0, M_FETCH = 1, M_ACT = 2, M_WAIT = 3, M_HALT = 4, M_DONE = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic ch_enable, ch_disable, prefetch_en, blk_done, sw_wr_en;
  logic [1:0] sw_wr_addr;
  logic [CW+2:0] sw_wr_data;
  logic [2:0] stat_en, sig_en;
  logic busy, halted, blk_start, xfer_done, shadow_valid, active_ioc, active_last, irq;
  logic [CW-1:0] active_ctrl;
  logic [2:0] int_status;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit cmp_on   = 0;
  bit finished = 0;

  // reference model state
  int ms;
  bit msv;
  bit [CW+1:0] msb, mact, mstg;
  bit mstgv;
  bit [2:0] mst;

  always #10 clk = ~clk;

  blkseq_ctrl #(.CTRL_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .ch_enable(ch_enable), .ch_disable(ch_disable),
    .prefetch_en(prefetch_en), .blk_done(blk_done), .sw_wr_en(sw_wr_en),
    .sw_wr_addr(sw_wr_addr), .sw_wr_data(sw_wr_data), .stat_en(stat_en), .sig_en(sig_en),
    .busy(busy), .halted(halted), .blk_start(blk_start), .xfer_done(xfer_done),
    .shadow_valid(shadow_valid), .active_ctrl(active_ctrl), .active_ioc(active_ioc),
    .active_last(active_last), .int_status(int_status), .irq(irq)
  );

  function automatic logic [CW+2:0] mk(bit v, bit l, bit i, logic [CW-1:0] p);
    return {v, l, i, p};
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      ms = M_IDLE; msv = 0; msb = '0; mact = '0; mstg = '0; mstgv = 0; mst = '0;
    end else begin
      bit wsh, wac, wres, wcl, dis, ldsh, inv, blk, ldst, pf, wov;
      int ns;
      bit [2:0] setv, clrv;
      bit [CW+1:0] osb;
      wsh  = sw_wr_en && sw_wr_addr == 2'd0;
      wac  = sw_wr_en && sw_wr_addr == 2'd1;
      wres = sw_wr_en && sw_wr_addr == 2'd2;
      wcl  = sw_wr_en && sw_wr_addr == 2'd3;
      dis  = ch_disable;
      osb  = msb;
      ldsh = ms == M_FETCH && msv && !dis;
      inv  = ms == M_FETCH && !msv && !dis;
      blk  = ms == M_WAIT && blk_done && !dis;
      ldst = blk && !mact[CW+1] && mstgv;
      pf   = (ms == M_ACT || (ms == M_WAIT && !blk_done)) && prefetch_en &&
             !mact[CW+1] && !mstgv && msv && !dis;
      wov  = wsh && msv;
      setv = {wov & stat_en[2], inv & stat_en[1], blk & mact[CW] & stat_en[0]};
      clrv = wcl ? sw_wr_data[2:0] : 3'b000;
      ns = ms;
      case (ms)
        M_IDLE:  if (ch_enable) ns = M_FETCH;
        M_FETCH: ns = msv ? M_ACT : M_HALT;
        M_ACT:   ns = M_WAIT;
        M_WAIT:  if (blk_done) ns = mact[CW+1] ? M_DONE : (mstgv ? M_ACT : M_FETCH);
        M_HALT:  if (wres) ns = M_FETCH;
        default: ns = M_IDLE;
      endcase
      if (dis) ns = M_IDLE;
      if (ldsh)      mact = osb;
      else if (ldst) mact = mstg;
      else if (wac && ms == M_IDLE) mact = sw_wr_data[CW+1:0];
      if (pf) begin mstg = osb; mstgv = 1; end
      else if (ldst || dis) mstgv = 0;
      if (wsh && !msv) begin msv = sw_wr_data[CW+2]; msb = sw_wr_data[CW+1:0]; end
      else if (ldsh || pf) msv = 0;
      mst = setv | (mst & ~clrv);
      ms = ns;
    end
  end

  // per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    #1;
    if (cmp_on && rst_n) begin
      chk("R1 busy", busy, ms != M_IDLE);
      chk("R2 blk_start", blk_start, ms == M_ACT);
      chk("R4 halted", halted, ms == M_HALT);
      chk("R6 xfer_done", xfer_done, ms == M_DONE);
      chk("R5 shadow_valid", shadow_valid, msv);
      chk("R8 active word", {active_last, active_ioc, active_ctrl}, mact);
      chk("R10 int_status", int_status, mst);
      chk("R7 irq", irq, |(mst & sig_en));
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      summary();
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(logic [1:0] a, logic [CW+2:0] d);
    sw_wr_en = 1; sw_wr_addr = a; sw_wr_data = d;
    tick(1);
    sw_wr_en = 0;
  endtask
  task automatic go();
    ch_enable = 1; tick(1); ch_enable = 0;
  endtask
  task automatic done_pulse();
    blk_done = 1; tick(1); blk_done = 0;
  endtask
  task automatic stop();
    ch_disable = 1; tick(1); ch_disable = 0;
  endtask

  initial begin
    rst_n = 0; ch_enable = 0; ch_disable = 0; prefetch_en = 0; blk_done = 0;
    sw_wr_en = 0; sw_wr_addr = 0; sw_wr_data = '0; stat_en = 3'b111; sig_en = 3'b111;
    tick(3);
    // R12 reset state
    chk("R12 busy", busy, 0);
    chk("R12 status", int_status, 0);
    chk("R12 shadow_valid", shadow_valid, 0);
    chk("R12 active", active_ctrl, 0);
    chk("R12 irq", irq, 0);
    rst_n = 1; cmp_on = 1;
    tick(1);

    // two-block transfer
    wr(2'd0, mk(1, 0, 1, 16'h00A1));
    go();
    chk("R1 busy after enable", busy, 1);
    tick(1);
    chk("R2 blk_start", blk_start, 1);
    chk("R2 active payload", active_ctrl, 16'h00A1);
    chk("R2 valid cleared", shadow_valid, 0);
    tick(1);
    wr(2'd0, mk(1, 1, 0, 16'h00B2));
    tick(2);
    done_pulse();
    chk("R7 block status", int_status[0], 1);
    chk("R7 irq", irq, 1);
    sig_en = 3'b110; tick(1);
    chk("R7 irq gated by sig_en", irq, 0);
    chk("R2 second block payload", active_ctrl, 16'h00B2);
    sig_en = 3'b111;
    tick(1);
    done_pulse();
    chk("R6 xfer_done", xfer_done, 1);
    tick(1);
    chk("R6 back to idle", busy, 0);
    wr(2'd3, 19'h1);
    chk("R10 cleared", int_status, 0);

    // write while valid
    wr(2'd0, mk(1, 1, 0, 16'h00C3));
    wr(2'd0, mk(1, 1, 1, 16'h00DD));
    chk("R5 wov status", int_status[2], 1);
    go();
    tick(1);
    chk("R5 dropped write", active_ctrl, 16'h00C3);
    go(); // R1 enable while busy ignored
    done_pulse();
    tick(1);
    wr(2'd3, 19'h7);

    // invalid descriptor, halt and resume
    go();
    tick(1);
    chk("R3 halted", halted, 1);
    chk("R3 invalid status", int_status[1], 1);
    tick(4);
    chk("R4 still halted", halted, 1);
    wr(2'd2, 19'h0);
    tick(1);
    chk("R4 halts again", halted, 1);
    wr(2'd0, mk(1, 1, 0, 16'h00E5));
    wr(2'd2, 19'h5A5A);
    tick(1);
    chk("R4 resumed payload", active_ctrl, 16'h00E5);
    tick(1);
    done_pulse();
    tick(1);
    wr(2'd3, 19'h7);

    // masked invalid error, then disable while halted
    stat_en = 3'b101;
    go();
    tick(1);
    chk("R3 halted masked", halted, 1);
    chk("R3 masked status", int_status[1], 0);
    stop();
    chk("R11 disable to idle", busy, 0);
    stat_en = 3'b111;

    // direct active writes
    wr(2'd1, 19'h1_0077);
    chk("R8 idle write", active_ctrl, 16'h0077);
    wr(2'd0, mk(1, 0, 0, 16'h0088));
    go();
    tick(2);
    wr(2'd1, 19'h0_0099);
    chk("R8 busy write ignored", active_ctrl, 16'h0088);
    wr(2'd0, mk(1, 1, 0, 16'h0011));
    stop();
    chk("R11 idle", busy, 0);
    chk("R11 shadow kept", shadow_valid, 1);
    go();
    tick(1);
    chk("R11 kept payload used", active_ctrl, 16'h0011);
    tick(1);
    done_pulse();
    tick(1);

    // prefetch success chain
    prefetch_en = 1;
    wr(2'd0, mk(1, 0, 1, 16'h0101));
    go();
    tick(3);
    chk("R9 no error while empty", int_status, 0);
    wr(2'd0, mk(1, 0, 0, 16'h0202));
    tick(1);
    chk("R9 prefetched", shadow_valid, 0);
    wr(2'd0, mk(1, 1, 1, 16'h0303));
    done_pulse();
    chk("R9 staged becomes active", active_ctrl, 16'h0202);
    chk("R9 blk_start", blk_start, 1);
    tick(1);
    chk("R9 second prefetch", shadow_valid, 0);
    done_pulse();
    chk("R9 third block", active_ctrl, 16'h0303);
    tick(1);
    done_pulse();
    chk("R6 prefetch done", xfer_done, 1);
    tick(1);
    wr(2'd3, 19'h7);

    // prefetch failure, error only after retry
    wr(2'd0, mk(1, 0, 0, 16'h0404));
    go();
    tick(5);
    chk("R9 no early error", int_status[1], 0);
    done_pulse();
    tick(1);
    chk("R9 retry halts", halted, 1);
    chk("R9 retry error", int_status[1], 1);
    stop();
    prefetch_en = 0;
    wr(2'd3, 19'h7);

    // set wins over clear
    wr(2'd0, mk(1, 1, 1, 16'h0707));
    go();
    tick(2);
    sw_wr_en = 1; sw_wr_addr = 2'd3; sw_wr_data = 19'h1; blk_done = 1;
    tick(1);
    sw_wr_en = 0; blk_done = 0;
    chk("R10 set wins", int_status[0], 1);
    tick(2);
    summary();
  end
endmodule